// File: doc/BRIEF.md
# Coprocessor Address Translator

This block sits between a 16-bit big-endian coprocessor and a 20-bit little-endian host memory bus. Every coprocessor access carries a 20-bit segmented address and a space flag (program or data). The block looks up a per-space table of page numbers to find the host page, maps the access onto the host bus in 16 KB pages, and reverses the byte lanes of data and byte enables in both directions. A table entry can mark a page as absent. Absent pages return zero on reads and discard writes. A small range of page numbers selects the host framebuffer. For those pages the low address bits are rearranged so that the host's interleaved picture memory looks linear to the coprocessor.

Until software turns on shared memory, program-space reads come from a local 16 KB boot ROM and do not reach the host. A configuration write sets or clears the shared-memory flag. A handshake write that puts the coprocessor back into halt clears the flag. Each request is answered by a one-cycle acknowledge one clock later, with the read data registered alongside it.

Top module: `cop_xlat`

## Requirements
- R1: After reset, cpAck and cpRdata are 0 and the shared-memory flag is clear, so the first program read is served from the ROM.
- R2: Every clock cycle with cpReq high produces cpAck high in the next cycle, and cpAck is low in every other cycle.
- R3: Program-space accesses (cpSpace=0) use the program table and data-space accesses (cpSpace=1) use the data table. The table index is cpAddr[19:14]: the row is bits 19:16 and the column is bits 15:14.
- R4: For a mapped entry outside the framebuffer range, hostAddr is the low 6 bits of the entry followed by cpAddr[13:0]. Entries other than 255 are below 64.
- R5: An entry of 255 marks the page absent. hostReq stays low for that access. A read answers with cpRdata = 0, and a write leaves host memory unchanged.
- R6: For entries 40 to 47, the 16 low bits of the host address are rearranged: bits 7:6 move to 14:13, bits 14:8 move to 12:6, and bits 15 and 5:0 keep their places. Bits 19:16 are not changed.
- R7: hostWdata is cpWdata with its two bytes exchanged, and hostBe is {cpBe[0],cpBe[1]}. cpRdata for a host read is hostRdata with its bytes exchanged, and a write acknowledge carries cpRdata = 0.
- R8: While the shared-memory flag is clear, program reads drive romAddr = cpAddr[13:1], keep hostReq low, and return romRdata unchanged. Data accesses and program writes are translated as usual. A serData write sets the flag from bit 5; the other bits have no effect.
- R9: A handshake write with hsData bit 0 = 0 clears the flag, and this takes priority over a serial-control write in the same cycle. A handshake write with bit 0 = 1 leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpReq | input | 1 | Coprocessor access request, one per cycle |
| cpWe | input | 1 | Access is a write |
| cpSpace | input | 1 | 0 = program space, 1 = data space |
| cpAddr | input | 20 | Coprocessor byte address |
| cpBe | input | 2 | Byte enables, big-endian lane order |
| cpWdata | input | 16 | Write data, big-endian |
| cpAck | output | 1 | Access completed (one cycle after request) |
| cpRdata | output | 16 | Read data, big-endian |
| serWe | input | 1 | Serial-control register write strobe |
| serData | input | 8 | Serial-control write value (bit 5 = shared memory on) |
| hsWe | input | 1 | Handshake register write strobe |
| hsData | input | 8 | Handshake write value (bit 0 = 0 means halt) |
| hostReq | output | 1 | Host memory access valid |
| hostWe | output | 1 | Host memory access is a write |
| hostAddr | output | 20 | Host byte address |
| hostBe | output | 2 | Host byte enables, little-endian lane order |
| hostWdata | output | 16 | Host write data |
| hostRdata | input | 16 | Host read data, same cycle as hostReq |
| romAddr | output | 13 | Boot ROM word address |
| romRdata | input | 16 | Boot ROM word |

## Verification
The hardest case to reach is a configuration write and a halting handshake write that land in the same cycle. Neither the host bus nor cpRdata shows the flag directly, so the stimulus issues that pair and then a program read, whose source (ROM or host) shows which write won. The framebuffer rearrangement only appears for the few table rows that hold entries 40 to 47. The bench gives both tables such rows and accesses addresses whose bits 7:6 and 14:8 are non-zero, then checks hostAddr and the read-back data against a bit-by-bit model.

// File: rtl/cop_xlat_pkg.sv
package cop_xlat_pkg;

  // Strobes from the control to the datapath for the current access.
  typedef struct packed {
    logic respond;   // an access is being answered next cycle
    logic romSel;    // serve from the local boot ROM
    logic hostGo;    // drive the host bus
    logic zeroResp;  // answer with zero data
  } xlatStrobes_t;

  localparam int DEF_ENTRIES = 64;
  localparam int DEF_MAP_W   = DEF_ENTRIES * 8;

  // Default page table: identity numbering, row 4 absent, row 3 on the
  // framebuffer pages; the data table moves row 1 onto the upper framebuffer pages.
  function automatic logic [DEF_MAP_W-1:0] copDefaultMap(input logic dataSide);
    logic [DEF_MAP_W-1:0] m;
    for (int i = 0; i < DEF_ENTRIES; i++) begin
      if ((i >> 2) == 4)                 m[i*8 +: 8] = 8'hFF;
      else if ((i >> 2) == 3)            m[i*8 +: 8] = 8'(40 + (i & 3));
      else if (dataSide && (i >> 2) == 1) m[i*8 +: 8] = 8'(44 + (i & 3));
      else                               m[i*8 +: 8] = 8'(i);
    end
    return m;
  endfunction

endpackage

// File: rtl/cop_xlat_ctrl.sv
module cop_xlat_ctrl
  import cop_xlat_pkg::*;
#(
  parameter int CFG_W     = 8,
  parameter int MEMEN_BIT = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpReq,
  input  logic             cpWe,
  input  logic             cpSpace,
  input  logic             entryUnmapped,
  input  logic             serWe,
  input  logic [CFG_W-1:0] serData,
  input  logic             hsWe,
  input  logic [CFG_W-1:0] hsData,
  output xlatStrobes_t     stb,
  output logic             memEn
);

  logic romSel;
  logic unusedCfgBits;

  assign unusedCfgBits = ^{serData, hsData};

  // Program reads go to the boot ROM until shared memory is on.
  assign romSel = cpReq && !cpWe && !cpSpace && !memEn;

  always_comb begin
    stb.respond  = cpReq;
    stb.romSel   = romSel;
    stb.hostGo   = cpReq && !romSel && !entryUnmapped;
    stb.zeroResp = cpWe || (entryUnmapped && !romSel);
  end

  // Halting the coprocessor wins over a same-cycle enable.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  memEn <= 1'b0;
    else if (hsWe && !hsData[0]) memEn <= 1'b0;
    else if (serWe)             memEn <= serData[MEMEN_BIT];
  end

endmodule

// File: rtl/cop_xlat_datapath.sv
module cop_xlat_datapath
  import cop_xlat_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int PAGE_BITS = 14,
  parameter int ENTRY_W   = 8,
  parameter logic [ENTRY_W-1:0] UNMAPPED = 8'hFF,
  parameter logic [ENTRY_W-1:0] FB_LO    = 8'd40,
  parameter logic [ENTRY_W-1:0] FB_HI    = 8'd47,
  parameter logic [((1 << (ADDR_W-PAGE_BITS))*ENTRY_W)-1:0] PROG_MAP = copDefaultMap(1'b0),
  parameter logic [((1 << (ADDR_W-PAGE_BITS))*ENTRY_W)-1:0] DATA_MAP = copDefaultMap(1'b1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  xlatStrobes_t        stb,
  input  logic                cpWe,
  input  logic                cpSpace,
  input  logic [ADDR_W-1:0]   cpAddr,
  input  logic [DATA_W/8-1:0] cpBe,
  input  logic [DATA_W-1:0]   cpWdata,
  output logic                entryUnmapped,
  output logic                cpAck,
  output logic [DATA_W-1:0]   cpRdata,
  output logic                hostReq,
  output logic                hostWe,
  output logic [ADDR_W-1:0]   hostAddr,
  output logic [DATA_W/8-1:0] hostBe,
  output logic [DATA_W-1:0]   hostWdata,
  input  logic [DATA_W-1:0]   hostRdata,
  output logic [PAGE_BITS-2:0] romAddr,
  input  logic [DATA_W-1:0]   romRdata
);

  localparam int SEG_W = ADDR_W - PAGE_BITS;
  localparam int LANES = DATA_W / 8;

  logic [SEG_W-1:0]   idx;
  logic [ENTRY_W-1:0] progEntry, dataEntry, entry;
  logic [ADDR_W-1:0]  rawAddr, fbAddr;
  logic               fbHit;
  logic [DATA_W-1:0]  rdSwap;
  logic               ackQ;
  logic [DATA_W-1:0]  rdataQ;

  assign idx       = cpAddr[ADDR_W-1:PAGE_BITS];
  assign progEntry = PROG_MAP[int'(idx)*ENTRY_W +: ENTRY_W];
  assign dataEntry = DATA_MAP[int'(idx)*ENTRY_W +: ENTRY_W];
  assign entry     = cpSpace ? dataEntry : progEntry;

  assign entryUnmapped = (entry == UNMAPPED);
  assign fbHit         = (entry >= FB_LO) && (entry <= FB_HI);

  assign rawAddr = {entry[SEG_W-1:0], cpAddr[PAGE_BITS-1:0]};
  // Framebuffer pages: lift bits 7:6 above the 14:8 group.
  assign fbAddr  = {rawAddr[ADDR_W-1:15], rawAddr[7:6], rawAddr[14:8], rawAddr[5:0]};

  assign hostAddr = fbHit ? fbAddr : rawAddr;
  assign hostReq  = stb.hostGo;
  assign hostWe   = stb.hostGo && cpWe;
  assign romAddr  = cpAddr[PAGE_BITS-1:1];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign hostWdata[g*8 +: 8] = cpWdata[(LANES-1-g)*8 +: 8];
    assign rdSwap[g*8 +: 8]    = hostRdata[(LANES-1-g)*8 +: 8];
    assign hostBe[g]           = cpBe[LANES-1-g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackQ   <= 1'b0;
      rdataQ <= '0;
    end else begin
      ackQ <= stb.respond;
      if (stb.respond)
        rdataQ <= stb.zeroResp ? '0 : (stb.romSel ? romRdata : rdSwap);
    end
  end

  assign cpAck   = ackQ;
  assign cpRdata = rdataQ;

endmodule

// File: rtl/cop_xlat.sv
module cop_xlat
  import cop_xlat_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int PAGE_BITS = 14,
  parameter int ENTRY_W   = 8,
  parameter int CFG_W     = 8,
  parameter int MEMEN_BIT = 5,
  parameter logic [((1 << (ADDR_W-PAGE_BITS))*ENTRY_W)-1:0] PROG_MAP = copDefaultMap(1'b0),
  parameter logic [((1 << (ADDR_W-PAGE_BITS))*ENTRY_W)-1:0] DATA_MAP = copDefaultMap(1'b1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cpReq,
  input  logic                 cpWe,
  input  logic                 cpSpace,
  input  logic [ADDR_W-1:0]    cpAddr,
  input  logic [DATA_W/8-1:0]  cpBe,
  input  logic [DATA_W-1:0]    cpWdata,
  output logic                 cpAck,
  output logic [DATA_W-1:0]    cpRdata,
  input  logic                 serWe,
  input  logic [CFG_W-1:0]     serData,
  input  logic                 hsWe,
  input  logic [CFG_W-1:0]     hsData,
  output logic                 hostReq,
  output logic                 hostWe,
  output logic [ADDR_W-1:0]    hostAddr,
  output logic [DATA_W/8-1:0]  hostBe,
  output logic [DATA_W-1:0]    hostWdata,
  input  logic [DATA_W-1:0]    hostRdata,
  output logic [PAGE_BITS-2:0] romAddr,
  input  logic [DATA_W-1:0]    romRdata
);

  xlatStrobes_t stb;
  logic         memEn;
  logic         entryUnmapped;

  cop_xlat_ctrl #(.CFG_W(CFG_W), .MEMEN_BIT(MEMEN_BIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpReq(cpReq), .cpWe(cpWe), .cpSpace(cpSpace),
    .entryUnmapped(entryUnmapped), .serWe(serWe), .serData(serData),
    .hsWe(hsWe), .hsData(hsData), .stb(stb), .memEn(memEn)
  );

  cop_xlat_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS), .ENTRY_W(ENTRY_W),
    .PROG_MAP(PROG_MAP), .DATA_MAP(DATA_MAP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cpWe(cpWe), .cpSpace(cpSpace),
    .cpAddr(cpAddr), .cpBe(cpBe), .cpWdata(cpWdata), .entryUnmapped(entryUnmapped),
    .cpAck(cpAck), .cpRdata(cpRdata), .hostReq(hostReq), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostBe(hostBe), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .romAddr(romAddr), .romRdata(romRdata)
  );

endmodule

// File: rtl/cop_xlat_checker.sv
module cop_xlat_checker #(
  parameter int DATA_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                cpReq,
  input logic                cpWe,
  input logic                cpSpace,
  input logic [DATA_W/8-1:0] cpBe,
  input logic                cpAck,
  input logic [DATA_W-1:0]   cpRdata,
  input logic                hostReq,
  input logic [DATA_W/8-1:0] hostBe,
  input logic                haltWrite,
  input logic                memEn,
  input logic                entryUnmapped
);

  logic romRead;
  assign romRead = cpReq && !cpWe && !cpSpace && !memEn;

  a_r2_ack_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    cpReq |=> cpAck);

  a_r2_no_spurious_ack: assert property (@(posedge clk) disable iff (!rstN)
    !cpReq |=> !cpAck);

  a_r5_absent_no_host: assert property (@(posedge clk) disable iff (!rstN)
    (cpReq && entryUnmapped && !romRead) |-> !hostReq);

  a_r5_absent_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cpReq && !cpWe && entryUnmapped && !romRead) |=> (cpRdata == '0));

  a_r7_lane_order: assert property (@(posedge clk) disable iff (!rstN)
    hostReq |-> (hostBe == {<<{cpBe}}));

  a_r8_rom_keeps_host_idle: assert property (@(posedge clk) disable iff (!rstN)
    romRead |-> !hostReq);

  a_r9_halt_clears_flag: assert property (@(posedge clk) disable iff (!rstN)
    haltWrite |=> !memEn);

endmodule

bind cop_xlat cop_xlat_checker #(.DATA_W(DATA_W)) u_checker (
  .clk(clk), .rstN(rstN), .cpReq(cpReq), .cpWe(cpWe), .cpSpace(cpSpace),
  .cpBe(cpBe), .cpAck(cpAck), .cpRdata(cpRdata), .hostReq(hostReq),
  .hostBe(hostBe), .haltWrite(hsWe && !hsData[0]), .memEn(memEn),
  .entryUnmapped(entryUnmapped)
);

// File: tb/cop_xlat_bench.sv
`timescale 1ns/1ps
module cop_xlat_bench;

  // Bench page tables (row = addr[19:16], column = addr[15:14]).
  function automatic int tbEntry(bit ds, int idx);
    int row, col;
    row = idx >> 2; col = idx & 3;
    if (!ds) begin
      if (row == 2) return 255;
      if (row == 5) return 40 + col;
      if (row == 6) return 44 + col;
      return (idx * 7 + 3) % 40;
    end else begin
      if (row == 9)  return 255;
      if (row == 3)  return 43 - col;
      if (row == 12) return 44 + col;
      return (idx * 11 + 1) % 40;
    end
  endfunction

  function automatic logic [511:0] tbMap(bit ds);
    logic [511:0] m;
    for (int i = 0; i < 64; i++) m[i*8 +: 8] = 8'(tbEntry(ds, i));
    return m;
  endfunction

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpReq = 1'b0, cpWe = 1'b0, cpSpace = 1'b0;
  logic [19:0] cpAddr = '0;
  logic [1:0]  cpBe = '0;
  logic [15:0] cpWdata = '0;
  logic        cpAck;
  logic [15:0] cpRdata;
  logic        serWe = 1'b0, hsWe = 1'b0;
  logic [7:0]  serData = '0, hsData = '0;
  logic        hostReq, hostWe;
  logic [19:0] hostAddr;
  logic [1:0]  hostBe;
  logic [15:0] hostWdata;
  logic [15:0] hostRdata;
  logic [12:0] romAddr;
  logic [15:0] romRdata;

  always #2 clk = ~clk;

  cop_xlat #(.PROG_MAP(tbMap(1'b0)), .DATA_MAP(tbMap(1'b1))) u_cop_xlat (
    .clk(clk), .rstN(rstN), .cpReq(cpReq), .cpWe(cpWe), .cpSpace(cpSpace),
    .cpAddr(cpAddr), .cpBe(cpBe), .cpWdata(cpWdata), .cpAck(cpAck), .cpRdata(cpRdata),
    .serWe(serWe), .serData(serData), .hsWe(hsWe), .hsData(hsData),
    .hostReq(hostReq), .hostWe(hostWe), .hostAddr(hostAddr), .hostBe(hostBe),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .romAddr(romAddr), .romRdata(romRdata)
  );

  // ---------------- environment: host memory and boot ROM ----------------
  logic [15:0] hostMem [int];
  int          memTick = 0;

  function automatic logic [15:0] pat(int w);
    return 16'((w * 40503 + 4660) & 16'hFFFF);
  endfunction

  always @(hostAddr or memTick) begin
    int w;
    w = int'(hostAddr) >> 1;
    hostRdata = hostMem.exists(w) ? hostMem[w] : pat(w);
  end

  always @(negedge clk) begin
    if (rstN && hostReq && hostWe) begin
      int w;
      logic [15:0] v;
      w = int'(hostAddr) >> 1;
      v = hostMem.exists(w) ? hostMem[w] : pat(w);
      if (hostBe[0]) v[7:0]  = hostWdata[7:0];
      if (hostBe[1]) v[15:8] = hostWdata[15:8];
      hostMem[w] = v;
      memTick++;
    end
  end

  function automatic logic [15:0] romWord(logic [12:0] a);
    return {3'b101, a} ^ 16'h0F0F;
  endfunction
  assign romRdata = romWord(romAddr);

  // ---------------- reference model ----------------
  int nChecks = 0, nFails = 0, cycles = 0;
  bit finished = 0;
  string curTag = "";
  logic [15:0] shadow [int];
  bit   mMemEn = 0;
  bit   expAck = 0;
  logic [15:0] expData = '0;
  string expTag = "R2";

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int xl(bit ds, int a);
    int e, h, lo, n;
    e = tbEntry(ds, (a >> 14) & 63);
    if (e == 255) return -1;
    h = (e % 64) * 16384 + (a % 16384);
    if (e >= 40 && e <= 47) begin
      lo = h % 65536; n = 0;
      for (int t = 0; t < 16; t++) begin
        int src;
        if (t == 15 || t < 6) src = t;
        else if (t >= 13)     src = t - 7;
        else                  src = t + 2;
        n = n | (((lo >> src) & 1) << t);
      end
      h = h - lo + n;
    end
    return h;
  endfunction

  function automatic bit isFb(bit ds, int a);
    int e;
    e = tbEntry(ds, (a >> 14) & 63);
    return e >= 40 && e <= 47;
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (rstN && !finished) begin
      chk(cpAck === expAck, "R2", {31'b0, cpAck}, {31'b0, expAck});
      if (expAck) chk(cpRdata === expData, expTag, {16'b0, cpRdata}, {16'b0, expData});
    end
    if (rstN && cpReq) begin
      int a, ha, w;
      bit rom;
      string t;
      logic [15:0] v;
      a   = int'(cpAddr);
      rom = !cpWe && !cpSpace && !mMemEn;
      ha  = xl(cpSpace, a);
      expAck = 1;
      if (rom) begin
        t = "R8";
        chk(hostReq === 1'b0, "R8", {31'b0, hostReq}, 0);
        chk(romAddr === cpAddr[13:1], "R8", {19'b0, romAddr}, {19'b0, cpAddr[13:1]});
        expData = romWord(cpAddr[13:1]);
      end else if (ha < 0) begin
        t = "R5";
        chk(hostReq === 1'b0, "R5", {31'b0, hostReq}, 0);
        expData = '0;
      end else begin
        t = isFb(cpSpace, a) ? "R6" : "R7";
        chk(hostReq === 1'b1, "R3/R4", {31'b0, hostReq}, 1);
        chk(hostWe === cpWe, "R7", {31'b0, hostWe}, {31'b0, cpWe});
        chk(hostAddr === 20'(ha), isFb(cpSpace, a) ? "R6" : "R3/R4",
            {12'b0, hostAddr}, ha);
        chk(hostBe === {cpBe[0], cpBe[1]}, "R7", {30'b0, hostBe}, {30'b0, cpBe[0], cpBe[1]});
        w = ha >> 1;
        v = shadow.exists(w) ? shadow[w] : pat(w);
        if (cpWe) begin
          chk(hostWdata === {cpWdata[7:0], cpWdata[15:8]}, "R7",
              {16'b0, hostWdata}, {16'b0, cpWdata[7:0], cpWdata[15:8]});
          if (cpBe[1]) v[7:0]  = cpWdata[15:8];
          if (cpBe[0]) v[15:8] = cpWdata[7:0];
          shadow[w] = v;
          expData = '0;
        end else begin
          expData = {v[7:0], v[15:8]};
        end
      end
      expTag = (curTag != "") ? curTag : t;
    end else begin
      expAck = 0;
    end
    if (!rstN)                   mMemEn = 0;
    else if (hsWe && !hsData[0]) mMemEn = 0;
    else if (serWe)              mMemEn = serData[5];
    if (cycles > 20000 && !finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      summary();
    end
  end

  task automatic summary();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  // ---------------- stimulus ----------------
  task automatic acc(bit we, bit sp, int addr, logic [15:0] wd, logic [1:0] be, string tag);
    @(posedge clk); #1;
    cpReq = 1; cpWe = we; cpSpace = sp; cpAddr = 20'(addr); cpWdata = wd; cpBe = be;
    curTag = tag;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      cpReq = 0; cpWe = 0; serWe = 0; hsWe = 0;
    end
  endtask

  task automatic cfg(bit s, logic [7:0] sd, bit h, logic [7:0] hd);
    @(posedge clk); #1;
    cpReq = 0; serWe = s; serData = sd; hsWe = h; hsData = hd;
    @(posedge clk); #1;
    serWe = 0; hsWe = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cpAck === 1'b0, "R1", {31'b0, cpAck}, 0);
    chk(cpRdata === 16'h0, "R1", {16'b0, cpRdata}, 0);
    @(posedge clk); #1 rstN = 1;
    idle(1);

    // R1: flag clear after reset, program read from ROM
    acc(0, 0, 'h00120, 0, 2'b11, "R1");
    idle(1);
    // R8: program reads from ROM, data unaffected, program write translated
    acc(0, 0, 'h52468, 0, 2'b11, "R8");
    acc(1, 0, 'h14000, 16'hC0DE, 2'b11, "R8");
    acc(0, 1, 'h00002, 0, 2'b11, "");
    acc(0, 1, 'h4C00A, 0, 2'b11, "R3");
    acc(0, 1, 'hA8FFE, 0, 2'b11, "R3");
    acc(0, 1, 'hFFFFE, 0, 2'b11, "R4");
    idle(1);
    // R5: absent data page
    acc(0, 1, 'h91234, 0, 2'b11, "R5");
    acc(1, 1, 'h90010, 16'hDEAD, 2'b11, "R5");
    idle(1);
    // R8: bits other than 5 do not enable
    cfg(1, 8'hDF, 0, 8'h00);
    acc(0, 0, 'h00444, 0, 2'b11, "R8");
    idle(1);
    cfg(1, 8'h20, 0, 8'h00);
    // mapped program reads, R3 per-space table
    acc(0, 0, 'h00444, 0, 2'b11, "R3");
    acc(0, 0, 'h1C002, 0, 2'b11, "R3");
    acc(0, 0, 'h14000, 0, 2'b11, "R7");
    acc(0, 0, 'h7BFFE, 0, 2'b11, "R4");
    acc(0, 0, 'h22000, 0, 2'b11, "R5");
    acc(1, 0, 'h2E000, 16'h1111, 2'b11, "R5");
    idle(1);
    // R6: framebuffer pages
    acc(0, 0, 'h500C4, 0, 2'b11, "R6");
    acc(0, 0, 'h67FFE, 0, 2'b11, "R6");
    acc(0, 1, 'h341C0, 0, 2'b11, "R6");
    acc(1, 1, 'hC9BC6, 16'h5AA5, 2'b11, "R6");
    acc(0, 1, 'hC9BC6, 0, 2'b11, "R6");
    acc(1, 0, 'h5FF3E, 16'h7E81, 2'b11, "R6");
    acc(0, 0, 'h5FF3E, 0, 2'b11, "R6");
    idle(1);
    // R7: byte lanes
    acc(1, 1, 'h10100, 16'hA1B2, 2'b11, "R7");
    acc(0, 1, 'h10100, 0, 2'b11, "R7");
    acc(1, 1, 'h10100, 16'h3344, 2'b10, "R7");
    acc(0, 1, 'h10100, 0, 2'b11, "R7");
    acc(1, 1, 'h10100, 16'h5566, 2'b01, "R7");
    acc(0, 1, 'h10100, 0, 2'b11, "R7");
    idle(2);
    // R2: back-to-back then gap
    for (int i = 0; i < 6; i++) acc(0, i & 1, 'h0A000 + i * 'h1_0006, 0, 2'b11, "R2");
    idle(3);
    // R9: run write keeps flag, halt write clears it
    cfg(0, 8'h00, 1, 8'h01);
    acc(0, 0, 'h00444, 0, 2'b11, "R9");
    idle(1);
    cfg(0, 8'h00, 1, 8'hFE);
    acc(0, 0, 'h00444, 0, 2'b11, "R9");
    idle(1);
    cfg(1, 8'h20, 1, 8'h00);
    acc(0, 0, 'h1C002, 0, 2'b11, "R9");
    idle(1);
    cfg(1, 8'h20, 0, 8'h00);
    acc(0, 0, 'h1C002, 0, 2'b11, "R9");
    idle(4);
    summary();
  end

endmodule